// File: doc/BRIEF.md
# Fabric Cell Switch with Multicast Bitmap Replication

This block forwards fabric cells to a set of destination processors. Each cell arrives on a valid/ready input with a kind flag, an identifier and a payload. A unicast cell names its destination directly in the identifier. A multicast cell uses the identifier as an index into a programmable group table. Each table entry is a bitmap of destination processors, and the block sends exactly one copy of the cell to every destination whose bit is set. Any replication behind a destination belongs to that destination, not to this block.

Software writes the group table through a simple write port, one entry per cycle. Groups that reach the same destination set can share one entry, so the table holds fan-out patterns rather than one row per group. Copies leave one per cycle on a shared payload bus, with a one-hot per-destination valid vector. A multicast cell is walked from its lowest set bit upward. The input is held off until the walk reaches its last copy. Cells that would reach nobody are discarded and counted.

Top module: `cellsw_fabric`

## Requirements
- R1: After reset, `out_valid` is all zeros, `in_ready` is 1, `drop_count` is 0, and every group table entry reads as an empty bitmap.
- R2: A unicast cell (`in_mcast`=0) accepted with `in_id` = d < N_DEST appears in the next cycle as `out_valid` = 1<<d with its payload, for that one cycle.
- R3: A multicast cell (`in_mcast`=1) accepted with group g emits one copy per set bit of table entry g, one per cycle, in ascending destination index. The first copy is in the cycle after acceptance, and the payload is unchanged across all copies.
- R4: `in_ready` is 0 while more than one copy of the current cell is still to be emitted. It is 1 during the cycle that emits the last copy, so a new cell accepted then follows without a gap.
- R5: A cell that reaches no destination is dropped. This covers a multicast cell whose entry is all zeros and a unicast cell with `in_id` >= N_DEST. A dropped cell produces no output, leaves `in_ready` at 1 and increments `drop_count` by one, which saturates at its maximum.
- R6: A table write to the group of the cell in flight does not change that cell's copies. This holds when the write comes in the acceptance cycle and when it comes during the walk. The next cell to use the group sees the last value written.
- R7: At most one bit of `out_valid` is set in any cycle.
- R8: A table write changes only the entry at `tbl_wr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input cell present |
| in_ready | output | 1 | Block can take a cell this cycle |
| in_mcast | input | 1 | 1 = multicast cell, 0 = unicast cell |
| in_id | input | ID_W | Destination index (unicast) or group index (multicast) |
| in_payload | input | PAYLOAD_W | Cell payload |
| tbl_wr_en | input | 1 | Group table write strobe |
| tbl_wr_addr | input | GRP_W | Group table entry to write |
| tbl_wr_bits | input | N_DEST | Destination bitmap to store |
| out_valid | output | N_DEST | One-hot copy strobe per destination |
| out_payload | output | PAYLOAD_W | Payload of the current copy |
| drop_count | output | CNT_W | Saturating count of dropped cells |

## Verification
Every result lands a fixed number of cycles after an input edge. The first copy of an accepted cell appears one cycle after acceptance. The k-th copy of a multicast cell appears k cycles after acceptance. The drop count moves one cycle after a dropped cell is accepted. A table write is visible to any cell accepted from the following cycle on. The bench drives on the falling edge and samples on the next falling edge, one check per expected copy. It also checks that the output is empty right after the last copy, so a missing, extra or reordered copy is caught in the cycle where it occurs.

// File: rtl/cellsw_pkg.sv
package cellsw_pkg;

   typedef enum logic {
      CELL_UCAST = 1'b0,
      CELL_MCAST = 1'b1
   } cell_kind_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cellsw_group_tbl.sv
module cellsw_group_tbl #(
   parameter int N_DEST         = 8,
   parameter int N_GROUPS       = 256,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int GRP_W         = $clog2(N_GROUPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [GRP_W-1:0]  wr_addr,
   input  logic [N_DEST-1:0] wr_bits,
   input  logic [GRP_W-1:0]  rd_addr,
   output logic [N_DEST-1:0] rd_bits
);

   logic [N_DEST-1:0] entry_q [N_GROUPS];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < N_GROUPS; i++) entry_q[i] <= '0;
            end else if (wr_en) begin
               entry_q[wr_addr] <= wr_bits;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (wr_en) entry_q[wr_addr] <= wr_bits;
         end
      end
   endgenerate

   // read is combinational from the stored array: a write lands at the edge,
   // so a cell sampled in the same cycle still sees the previous entry
   assign rd_bits = entry_q[rd_addr];

endmodule

// File: rtl/cellsw_lsb_pick.sv
module cellsw_lsb_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0] vec,
   output logic [N-1:0] pick,
   output logic [N-1:0] rest
);

   logic [N:0] seen;

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign pick[i]   = vec[i] & ~seen[i];
         assign seen[i+1] = seen[i] | vec[i];
      end
   endgenerate

   assign rest = vec & ~pick;

endmodule

// File: rtl/cellsw_walker.sv
module cellsw_walker #(
   parameter int N_DEST    = 8,
   parameter int PAYLOAD_W = 32,
   parameter int CNT_W     = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic [N_DEST-1:0]    take_bits,
   input  logic [PAYLOAD_W-1:0] take_payload,
   output logic [N_DEST-1:0]    cur_pick,
   output logic [PAYLOAD_W-1:0] cur_payload,
   output logic                 can_take,
   output logic [CNT_W-1:0]     drops
);

   logic [N_DEST-1:0]    pend_q;
   logic [N_DEST-1:0]    rest;
   logic [PAYLOAD_W-1:0] pay_q;
   logic [CNT_W-1:0]     drop_q;

   cellsw_lsb_pick #(.N(N_DEST)) pick_i (
      .vec  (pend_q),
      .pick (cur_pick),
      .rest (rest)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         pay_q  <= '0;
         drop_q <= '0;
      end else begin
         if (take) begin
            pend_q <= take_bits;
            pay_q  <= take_payload;
            if (take_bits == '0 && drop_q != '1) drop_q <= drop_q + 1'b1;
         end else begin
            pend_q <= rest;
         end
      end
   end

   assign can_take    = (rest == '0);
   assign cur_payload = pay_q;
   assign drops       = drop_q;

endmodule

// File: rtl/cellsw_fabric.sv
module cellsw_fabric
   import cellsw_pkg::*;
#(
   parameter int N_DEST         = 8,
   parameter int N_GROUPS       = 256,
   parameter int PAYLOAD_W      = 32,
   parameter int CNT_W          = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int DEST_W        = $clog2(N_DEST),
   localparam int GRP_W         = $clog2(N_GROUPS),
   localparam int ID_W          = max2(DEST_W, GRP_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic                 in_mcast,
   input  logic [ID_W-1:0]      in_id,
   input  logic [PAYLOAD_W-1:0] in_payload,
   input  logic                 tbl_wr_en,
   input  logic [GRP_W-1:0]     tbl_wr_addr,
   input  logic [N_DEST-1:0]    tbl_wr_bits,
   output logic [N_DEST-1:0]    out_valid,
   output logic [PAYLOAD_W-1:0] out_payload,
   output logic [CNT_W-1:0]     drop_count
);

   generate
      if (N_DEST < 2)                  begin : g_bad_dest  $error("N_DEST must be at least 2");        end
      if ((1 << GRP_W) != N_GROUPS)    begin : g_bad_grp   $error("N_GROUPS must be a power of two"); end
      if (CNT_W < 1 || PAYLOAD_W < 1)  begin : g_bad_width $error("widths must be positive");         end
   endgenerate

   cell_kind_e        kind;
   logic              accept;
   logic [N_DEST-1:0] grp_bits;
   logic [N_DEST-1:0] uc_bits;
   logic [N_DEST-1:0] new_bits;

   assign kind   = cell_kind_e'(in_mcast);
   assign accept = in_valid & in_ready;

   cellsw_group_tbl #(
      .N_DEST         (N_DEST),
      .N_GROUPS       (N_GROUPS),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) tbl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr_en),
      .wr_addr (tbl_wr_addr),
      .wr_bits (tbl_wr_bits),
      .rd_addr (in_id[GRP_W-1:0]),
      .rd_bits (grp_bits)
   );

   // unicast decode: an identifier outside the destination range sets no bit
   generate
      for (genvar d = 0; d < N_DEST; d++) begin : g_uc
         assign uc_bits[d] = (in_id == ID_W'(d));
      end
   endgenerate

   assign new_bits = (kind == CELL_MCAST) ? grp_bits : uc_bits;

   cellsw_walker #(
      .N_DEST    (N_DEST),
      .PAYLOAD_W (PAYLOAD_W),
      .CNT_W     (CNT_W)
   ) walk_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .take         (accept),
      .take_bits    (new_bits),
      .take_payload (in_payload),
      .cur_pick     (out_valid),
      .cur_payload  (out_payload),
      .can_take     (in_ready),
      .drops        (drop_count)
   );

endmodule

// File: rtl/cellsw_fabric_chk.sv
module cellsw_fabric_chk #(
   parameter int N_DEST    = 8,
   parameter int ID_W      = 8,
   parameter int PAYLOAD_W = 32,
   parameter int CNT_W     = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic                 in_mcast,
   input logic [ID_W-1:0]      in_id,
   input logic [N_DEST-1:0]    out_valid,
   input logic [PAYLOAD_W-1:0] out_payload,
   input logic [CNT_W-1:0]     drop_count
);

   AST_UCAST_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_mcast && in_id < ID_W'(N_DEST))
      |=> out_valid == (N_DEST'(1) << $past(in_id))); // R2

   AST_MC_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid != '0 && $past(out_valid) != '0 && !$past(in_valid && in_ready))
      |-> out_valid > $past(out_valid)); // R3

   AST_MC_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid != '0 && $past(out_valid) != '0 && !$past(in_valid && in_ready))
      |-> $stable(out_payload)); // R3

   AST_BUSY_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> out_valid != '0); // R4

   AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_count != $past(drop_count))
      |-> (drop_count == $past(drop_count) + 1'b1) && $past(in_valid && in_ready)); // R5

   AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_valid)); // R7

endmodule

bind cellsw_fabric cellsw_fabric_chk #(
   .N_DEST    (N_DEST),
   .ID_W      (ID_W),
   .PAYLOAD_W (PAYLOAD_W),
   .CNT_W     (CNT_W)
) chk_i (.*);

// File: tb/cellsw_fabric_tb_top.sv
`timescale 1ns/1ps
module cellsw_fabric_tb_top;

   localparam int N_DEST = 8;
   localparam int N_GRP  = 256;
   localparam int PW     = 32;
   localparam int CW     = 16;
   localparam int IDW    = 8;
   localparam int NV     = 12;

   // {mcast, id, payload[15:0], expected destination bitmap}
   localparam logic [32:0] VEC [NV] = '{
      {1'b0, 8'd0,   16'hA000, 8'h01},
      {1'b0, 8'd7,   16'hA007, 8'h80},
      {1'b0, 8'd3,   16'hA003, 8'h08},
      {1'b1, 8'd1,   16'hB001, 8'h81},
      {1'b1, 8'd2,   16'hB002, 8'hFF},
      {1'b1, 8'd3,   16'hB003, 8'h00},
      {1'b1, 8'd4,   16'hB004, 8'h81},
      {1'b1, 8'd200, 16'hB0C8, 8'h2C},
      {1'b1, 8'd255, 16'hB0FF, 8'h40},
      {1'b0, 8'd9,   16'hC009, 8'h00},
      {1'b1, 8'd0,   16'hB000, 8'h00},
      {1'b0, 8'd5,   16'hA005, 8'h20}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic              in_mcast = 1'b0;
   logic [IDW-1:0]    in_id = '0;
   logic [PW-1:0]     in_payload = '0;
   logic              tbl_wr_en = 1'b0;
   logic [7:0]        tbl_wr_addr = '0;
   logic [N_DEST-1:0] tbl_wr_bits = '0;
   logic [N_DEST-1:0] out_valid;
   logic [PW-1:0]     out_payload;
   logic [CW-1:0]     drop_count;

   int  n_checks = 0;
   int  n_fails  = 0;
   int  drop_exp = 0;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   cellsw_fabric dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_mcast    (in_mcast),
      .in_id       (in_id),
      .in_payload  (in_payload),
      .tbl_wr_en   (tbl_wr_en),
      .tbl_wr_addr (tbl_wr_addr),
      .tbl_wr_bits (tbl_wr_bits),
      .out_valid   (out_valid),
      .out_payload (out_payload),
      .drop_count  (drop_count)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
   endtask

   // all tasks enter and leave just after a falling edge
   task automatic tbl_write(input logic [7:0] addr, input logic [N_DEST-1:0] bits);
      tbl_wr_en = 1'b1; tbl_wr_addr = addr; tbl_wr_bits = bits;
      @(negedge clk);
      tbl_wr_en = 1'b0;
   endtask

   task automatic expect_copies(input string req, input logic [N_DEST-1:0] mask,
                                input logic [PW-1:0] pay);
      logic [N_DEST-1:0] rem = mask;
      for (int i = 0; i < N_DEST; i++) begin
         if (rem[i]) begin
            rem[i] = 1'b0;
            check(req, "copy strobe", 64'(out_valid), 64'(N_DEST'(1) << i));
            check(req, "copy payload", 64'(out_payload), 64'(pay));
            check("R4", "ready during copy", 64'(in_ready), 64'(rem == '0));
            check("R7", "one strobe", 64'($countones(out_valid) <= 1), 64'(1));
            @(negedge clk);
         end
      end
      check(req, "idle after copies", 64'(out_valid), 64'(0));
   endtask

   task automatic send(input string req, input bit mc, input logic [IDW-1:0] id,
                       input logic [PW-1:0] pay, input logic [N_DEST-1:0] mask);
      check(req, "ready before send", 64'(in_ready), 64'(1));
      in_valid = 1'b1; in_mcast = mc; in_id = id; in_payload = pay;
      @(negedge clk);
      in_valid = 1'b0;
      if (mask == '0) begin
         drop_exp++;
         check("R5", "ready after drop", 64'(in_ready), 64'(1));
      end
      expect_copies(req, mask, pay);
      check("R5", "drop count", 64'(drop_count), 64'(drop_exp));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: actual running expected done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "out_valid in reset", 64'(out_valid), 64'(0));
      check("R1", "ready in reset", 64'(in_ready), 64'(1));
      check("R1", "drop count in reset", 64'(drop_count), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "out_valid after reset", 64'(out_valid), 64'(0));

      tbl_write(8'd1,   8'h81);
      tbl_write(8'd2,   8'hFF);
      tbl_write(8'd4,   8'h81);
      tbl_write(8'd200, 8'h2C);
      tbl_write(8'd255, 8'h40);

      for (int v = 0; v < NV; v++) begin
         string tag;
         logic [32:0] e = VEC[v];
         if (e[7:0] == 8'h00)       tag = (v == 10) ? "R1" : "R5";
         else if (e[32])            tag = "R3";
         else                       tag = "R2";
         send(tag, e[32], e[31:24], PW'(e[23:8]), e[7:0]);
      end

      // R4: next cell taken while the last copy is out
      tbl_write(8'd6, 8'h16);
      in_valid = 1'b1; in_mcast = 1'b1; in_id = 8'd6; in_payload = 32'hD006;
      @(negedge clk);
      in_valid = 1'b0;
      check("R4", "copy 1", 64'(out_valid), 64'h02);
      check("R4", "ready busy 1", 64'(in_ready), 64'(0));
      @(negedge clk);
      check("R4", "copy 2", 64'(out_valid), 64'h04);
      check("R4", "ready busy 2", 64'(in_ready), 64'(0));
      @(negedge clk);
      check("R4", "last copy", 64'(out_valid), 64'h10);
      check("R4", "ready on last", 64'(in_ready), 64'(1));
      in_valid = 1'b1; in_mcast = 1'b0; in_id = 8'd6; in_payload = 32'hD106;
      @(negedge clk);
      in_valid = 1'b0;
      check("R4", "back-to-back strobe", 64'(out_valid), 64'h40);
      check("R4", "back-to-back payload", 64'(out_payload), 64'hD106);
      @(negedge clk);
      check("R4", "idle after", 64'(out_valid), 64'(0));

      // R6: writes in the accept cycle and mid-walk do not touch the cell in flight
      tbl_write(8'd7, 8'h0C);
      in_valid = 1'b1; in_mcast = 1'b1; in_id = 8'd7; in_payload = 32'hE007;
      tbl_wr_en = 1'b1; tbl_wr_addr = 8'd7; tbl_wr_bits = 8'h30;
      @(negedge clk);
      in_valid = 1'b0;
      tbl_wr_bits = 8'hC0;
      check("R6", "old copy 1", 64'(out_valid), 64'h04);
      @(negedge clk);
      tbl_wr_en = 1'b0;
      check("R6", "old copy 2", 64'(out_valid), 64'h08);
      check("R6", "old payload", 64'(out_payload), 64'hE007);
      @(negedge clk);
      check("R6", "walk ended", 64'(out_valid), 64'(0));
      send("R6", 1'b1, 8'd7, 32'hE107, 8'hC0);

      // R8: neighbours of the rewritten entry keep their contents
      send("R8", 1'b1, 8'd6, 32'hF006, 8'h16);
      send("R8", 1'b1, 8'd8, 32'hF008, 8'h00);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule